// File: doc/BRIEF.md
# Reset Source Capture Controller

This block records why the chip went through reset and fixes the boot and clock-mode configuration at the moment reset ends. Hardware reset requests come from the power-on reset (the block's own asynchronous reset `rst_ni`), an external reset pin, a watchdog and a clock loss-of-lock detector. Software can request a system reset or an external reset through a control register. Any request asserts the reset output. The output stays asserted for a fixed stretch after the last request goes away.

In the cycle where the reset output negates, the 2-bit boot strap and the 2-bit PLL strap are captured into the mode outputs, but only if the strap-enable input is high. If it is low, fixed defaults are loaded instead. A sticky status register holds one flag per reset cause. It is read, together with the control register, over a single-cycle 32-bit register port.

Top module: `rst_cause_ctrl`

## Requirements
- R1: `sys_rst_o` is high while `rst_ni` is low. It goes high in the cycle after any request is sampled. It stays high until STRETCH_CYC (16) clock edges have passed with no request, and it falls on the 16th such edge. A request sampled during the stretch restarts it.
- R2: After power-on reset, the status register (byte offset 0x0C) reads 0x0000_0001. Bit 0 is the power-on flag.
- R3: A single hardware request that starts a new reset event replaces the whole status register with that source's bit. The bits are: bit 1 external pin, bit 2 watchdog, bit 3 loss of lock.
- R4: Requests sampled in the same cycle set all of their status bits together. Requests sampled while the reset output is still high are added to the current event's flags.
- R5: Status bits stay unchanged until a new reset request arrives. This holds across many idle cycles and across register reads.
- R6: Writing 1 to bit 1 of the control register (offset 0x10) requests a software external reset. It sets status bit 5 and keeps every bit that was already set. It also asserts `sys_rst_o`.
- R7: Writing 1 to bit 0 of the control register requests a software system reset. It starts a new event whose status is bit 4 alone. Both control bits clear themselves, so the control register always reads 0.
- R8: When `cfg_en_i` is high at the clock edge where `sys_rst_o` falls, `boot_mode_o` and `pll_mode_o` take the values on `boot_strap_i` and `pll_strap_i`.
- R9: When `cfg_en_i` is low at that edge, both mode outputs load 2'b00. The mode outputs are 2'b00 during power-on reset and do not change at any other time, whatever the strap pins do.
- R10: Writes to the status register are ignored. Unused status bits read as zero. Any address other than 0x0C reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| ext_rst_req_i | input | 1 | External pin reset request |
| wdog_rst_req_i | input | 1 | Watchdog reset request |
| lol_rst_req_i | input | 1 | Loss-of-lock reset request |
| cfg_en_i | input | 1 | Strap sampling enable |
| boot_strap_i | input | 2 | Boot strap pins |
| pll_strap_i | input | 2 | PLL strap pins |
| reg_sel_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write enable |
| reg_addr_i | input | 8 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| sys_rst_o | output | 1 | Stretched reset output |
| boot_mode_o | output | 2 | Latched boot mode |
| pll_mode_o | output | 2 | Latched PLL mode |

## Verification
The bench builds the block with its default parameters: a 16-cycle stretch, 8-bit addresses and 2-bit straps. With the short stretch, every reset episode finishes in about twenty cycles. That leaves room for dozens of random episodes, each with a varying set of overlapping hardware sources, strap values and enable settings, each checked for exact negation timing. The narrow strap width lets the random draws cover every boot and PLL code. Directed cases reach restarting the stretch mid-way, a software external reset on top of earlier flags, and writes to the status register that must be ignored.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned NSRC      = 6;
  localparam int unsigned SRC_POR   = 0;
  localparam int unsigned SRC_EXT   = 1;
  localparam int unsigned SRC_WDOG  = 2;
  localparam int unsigned SRC_LOL   = 3;
  localparam int unsigned SRC_SWSYS = 4;
  localparam int unsigned SRC_SWEXT = 5;
  localparam int unsigned CTRL_SYS_BIT = 0;
  localparam int unsigned CTRL_EXT_BIT = 1;
  typedef logic [NSRC-1:0] src_vec_t;
  localparam src_vec_t SWEXT_MASK = src_vec_t'(1) << SRC_SWEXT;
  localparam src_vec_t POR_MASK   = src_vec_t'(1) << SRC_POR;
endpackage

// File: rtl/rsc_regif.sv
module rsc_regif
  import rsc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h0C,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  src_vec_t          status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sw_sys_o,
  output logic              sw_ext_o
);
  logic ctrl_wr;
  assign ctrl_wr = sel_i && we_i && (addr_i == CTRL_OFS);

  // request bits live one cycle only: self-clearing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_sys_o <= 1'b0;
      sw_ext_o <= 1'b0;
    end else begin
      sw_sys_o <= ctrl_wr && wdata_i[CTRL_SYS_BIT];
      sw_ext_o <= ctrl_wr && wdata_i[CTRL_EXT_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i && addr_i == STAT_OFS) rdata_o[NSRC-1:0] = status_i;
  end

  a_r10_ctrl_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && addr_i == CTRL_OFS) |-> (rdata_o == '0));
  a_r7_sw_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> (!sw_sys_o && !sw_ext_o));
endmodule

// File: rtl/rsc_stretch.sv
module rsc_stretch #(
  parameter int unsigned STRETCH_CYC = 16,
  localparam int unsigned CNT_W = $clog2(STRETCH_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_any_i,
  output logic rst_act_o,
  output logic negate_o
);
  logic [CNT_W-1:0] cnt_q;

  assign negate_o = rst_act_o && !req_any_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_act_o <= 1'b1;
      cnt_q     <= CNT_W'(STRETCH_CYC);
    end else if (req_any_i) begin
      rst_act_o <= 1'b1;
      cnt_q     <= CNT_W'(STRETCH_CYC);
    end else if (rst_act_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (negate_o) rst_act_o <= 1'b0;
    end
  end

  a_r1_req_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_any_i |=> rst_act_o);
  a_r1_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_act_o && !negate_o) |=> rst_act_o);
  a_r1_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    negate_o |=> !rst_act_o);
endmodule

// File: rtl/rsc_status.sv
module rsc_status
  import rsc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t req_i,
  input  logic     rst_act_i,
  output src_vec_t status_o
);
  logic new_evt;
  // a new event replaces flags unless it is a software external reset alone
  assign new_evt = !rst_act_i && ((req_i & ~SWEXT_MASK) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               status_o <= POR_MASK;
    else if (new_evt)          status_o <= req_i;
    else if (req_i != '0)      status_o <= status_o | req_i;
  end

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> $stable(status_o));
  a_r4_all_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |=> ((status_o & $past(req_i)) == $past(req_i)));
  a_r6_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == SWEXT_MASK) |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: rtl/rsc_strap.sv
module rsc_strap #(
  parameter int unsigned STRAP_W = 2,
  parameter logic [STRAP_W-1:0] BOOT_DEF = '0,
  parameter logic [STRAP_W-1:0] PLL_DEF  = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               negate_i,
  input  logic               cfg_en_i,
  input  logic [STRAP_W-1:0] boot_i,
  input  logic [STRAP_W-1:0] pll_i,
  output logic [STRAP_W-1:0] boot_o,
  output logic [STRAP_W-1:0] pll_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_o <= BOOT_DEF;
      pll_o  <= PLL_DEF;
    end else if (negate_i) begin
      boot_o <= cfg_en_i ? boot_i : BOOT_DEF;
      pll_o  <= cfg_en_i ? pll_i  : PLL_DEF;
    end
  end

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !negate_i |=> ($stable(boot_o) && $stable(pll_o)));
  a_r8_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (negate_i && cfg_en_i) |=> (boot_o == $past(boot_i) && pll_o == $past(pll_i)));
  a_r9_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (negate_i && !cfg_en_i) |=> (boot_o == BOOT_DEF && pll_o == PLL_DEF));
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h0C,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h10,
  parameter int unsigned STRAP_W = 2,
  parameter logic [STRAP_W-1:0] BOOT_DEF = '0,
  parameter logic [STRAP_W-1:0] PLL_DEF  = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_req_i,
  input  logic               wdog_rst_req_i,
  input  logic               lol_rst_req_i,
  input  logic               cfg_en_i,
  input  logic [STRAP_W-1:0] boot_strap_i,
  input  logic [STRAP_W-1:0] pll_strap_i,
  input  logic               reg_sel_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               sys_rst_o,
  output logic [STRAP_W-1:0] boot_mode_o,
  output logic [STRAP_W-1:0] pll_mode_o
);
  src_vec_t req, status;
  logic sw_sys, sw_ext, negate;

  always_comb begin
    req            = '0;
    req[SRC_EXT]   = ext_rst_req_i;
    req[SRC_WDOG]  = wdog_rst_req_i;
    req[SRC_LOL]   = lol_rst_req_i;
    req[SRC_SWSYS] = sw_sys;
    req[SRC_SWEXT] = sw_ext;
  end

  rsc_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .CTRL_OFS(CTRL_OFS)) u_regif (
    .clk_i, .rst_ni, .sel_i(reg_sel_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .status_i(status), .rdata_o(reg_rdata_o),
    .sw_sys_o(sw_sys), .sw_ext_o(sw_ext));

  rsc_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk_i, .rst_ni, .req_any_i(req != '0), .rst_act_o(sys_rst_o), .negate_o(negate));

  rsc_status u_status (
    .clk_i, .rst_ni, .req_i(req), .rst_act_i(sys_rst_o), .status_o(status));

  rsc_strap #(.STRAP_W(STRAP_W), .BOOT_DEF(BOOT_DEF), .PLL_DEF(PLL_DEF)) u_strap (
    .clk_i, .rst_ni, .negate_i(negate), .cfg_en_i, .boot_i(boot_strap_i),
    .pll_i(pll_strap_i), .boot_o(boot_mode_o), .pll_o(pll_mode_o));
endmodule

// File: tb/rst_cause_ctrl_test.sv
module rst_cause_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_r = 0, wd_r = 0, lol_r = 0, cfg_en = 0;
  logic [1:0] bstrap = 0, pstrap = 0, boot_m, pll_m;
  logic sel = 0, we = 0, srst;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rst_cause_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_req_i(ext_r), .wdog_rst_req_i(wd_r),
    .lol_rst_req_i(lol_r), .cfg_en_i(cfg_en), .boot_strap_i(bstrap), .pll_strap_i(pstrap),
    .reg_sel_i(sel), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sys_rst_o(srst), .boot_mode_o(boot_m), .pll_mode_o(pll_m));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(logic en, logic [1:0] s);
    return en ? s : 2'b00;
  endfunction

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  // caller is at the negedge right after the last request edge
  task automatic wait_release(string tag);
    bit ok = 1;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (srst !== 1'b1) ok = 0;
    end
    chk({tag, " R1 held 15"}, 32'(ok), 32'd1);
    @(negedge clk);
    chk({tag, " R1 falls"}, 32'(srst), 32'd0);
  endtask

  logic [31:0] d;

  initial begin
    void'($urandom(32'h1234_5eed));
    cfg_en = 1; bstrap = 2'b10; pstrap = 2'b01;
    repeat (3) @(negedge clk);
    chk("R1 srst in por", 32'(srst), 32'd1);
    chk("R9 boot in por", 32'(boot_m), 32'd0);
    chk("R9 pll in por", 32'(pll_m), 32'd0);
    rst_n = 1;
    wait_release("por");
    chk("R8 boot por", 32'(boot_m), 32'd2);
    chk("R8 pll por", 32'(pll_m), 32'd1);
    rd(8'h0C, d); chk("R2 status por", d, 32'h1);

    // R9: strap changes while idle leave modes alone
    bstrap = 2'b01; pstrap = 2'b11;
    repeat (4) @(negedge clk);
    chk("R9 hold boot", 32'(boot_m), 32'd2);

    // R10: status write ignored, other addrs zero
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R10 status write ignored", d, 32'h1);
    rd(8'h04, d); chk("R10 other addr", d, 32'h0);
    chk("R10 no reset on status write", 32'(srst), 32'd0);

    // R3 single watchdog, cfg off
    cfg_en = 0;
    @(negedge clk); wd_r = 1;
    @(negedge clk); wd_r = 0;
    wait_release("wdog");
    chk("R9 default boot", 32'(boot_m), 32'd0);
    chk("R9 default pll", 32'(pll_m), 32'd0);
    repeat (20) @(negedge clk);
    rd(8'h0C, d); chk("R3 R5 wdog only", d, 32'h4);

    // R6 sw external keeps wdog flag
    cfg_en = 1; bstrap = 2'b11; pstrap = 2'b10;
    wr(8'h10, 32'h2);
    @(negedge clk);
    wait_release("swext");
    rd(8'h0C, d); chk("R6 keep flags", d, 32'h24);
    chk("R8 boot swext", 32'(boot_m), 32'd3);
    rd(8'h10, d); chk("R7 ctrl reads zero", d, 32'h0);

    // R7 sw system replaces
    wr(8'h10, 32'h1);
    @(negedge clk);
    wait_release("swsys");
    rd(8'h0C, d); chk("R7 swsys only", d, 32'h10);

    // R4 simultaneous + restart mid-stretch
    @(negedge clk); ext_r = 1; lol_r = 1;
    @(negedge clk); ext_r = 0; lol_r = 0;
    repeat (5) @(negedge clk);
    chk("R1 mid stretch", 32'(srst), 32'd1);
    wd_r = 1;
    @(negedge clk); wd_r = 0;
    wait_release("restart");
    rd(8'h0C, d); chk("R4 simultaneous plus late", d, 32'hE);

    // random episodes
    for (int ep = 0; ep < 40; ep++) begin
      logic [2:0] m, acc;
      logic en;
      logic [1:0] bs, ps;
      int len;
      en = 1'($urandom_range(0, 1));
      bs = 2'($urandom_range(0, 3));
      ps = 2'($urandom_range(0, 3));
      len = int'($urandom_range(1, 3));
      cfg_en = en; bstrap = bs; pstrap = ps;
      acc = 0;
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        m = 3'($urandom_range(1, 7));
        {lol_r, wd_r, ext_r} = m;
        acc |= m;
      end
      @(negedge clk); {lol_r, wd_r, ext_r} = 3'b000;
      wait_release("rand");
      chk("R8 R9 rand boot", 32'(boot_m), 32'(exp_mode(en, bs)));
      chk("R8 R9 rand pll", 32'(pll_m), 32'(exp_mode(en, ps)));
      rd(8'h0C, d); chk("R3 R4 rand status", d, 32'(acc) << 1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule